// File: doc/BRIEF.md
# Packed SIMD Left Shifter with Sticky Overflow

This unit shifts a 32-bit word left by a shift count. The word is split into independent lanes: either four byte lanes or two halfword lanes. Bits that leave a lane are dropped, and zeros enter from the right. The shifted word is captured in a result register on any clock edge where the valid strobe is high.

Each lane also checks whether its shift lost information. Byte lanes use an unsigned rule: losing any 1 bit counts as overflow. Halfword lanes use a signed rule: they overflow when the lane's value no longer fits as a signed number. An overflow in any lane sets bit 22 of a 32-bit status word. That bit is sticky. Software can load the whole status word through a write port, and that write is the only way to clear the bit.

The unit is meant to sit in the execute stage of a packed-arithmetic pipeline. It is used with an immediate shift count. Software clears the status word, runs a sequence of shifts, and then reads bit 22 to learn whether any of them overflowed.

Top module: `lane_shl_unit`

## Requirements
- R1: With `halfMode`=0 each of the four 8-bit lanes (bits 7:0, 15:8, 23:16, 31:24) is shifted left by `shiftAmt[2:0]` with zero fill. `shiftAmt[3]` has no effect in this mode.
- R2: In byte mode with shift s>0, a lane overflows when any of its s most significant bits is 1.
- R3: With `halfMode`=1 each of the two 16-bit lanes (bits 15:0, 31:16) is shifted left by the full 4-bit `shiftAmt` (0 to 15) with zero fill.
- R4: In halfword mode with shift s>0, a lane overflows unless its s+1 most significant bits are all equal. Examples: operand 0x7FFF8000 shifted by 1 gives 0xFFFE0000 with overflow; operand 0x00000001 shifted by 15 gives 0x00008000 with overflow.
- R5: A shift of zero (`shiftAmt[2:0]`=0 in byte mode, `shiftAmt`=0 in halfword mode) copies the operand to the result and never raises overflow.
- R6: On a clock edge with `inValid`=1, `result` loads the shifted word, and an overflow in any lane sets `csrValue[22]`. With `inValid`=0, `result` holds and no flag is set.
- R7: Once `csrValue[22]` is 1, it stays 1 until a status write.
- R8: On a clock edge with `csrWrEn`=1, `csrValue` loads `csrWrData`. If a flag set happens in the same edge, bit 22 becomes 1 whatever the written value.
- R9: A synchronous active-high `rst` clears `csrValue` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| operand | input | 32 | Packed source word |
| shiftAmt | input | 4 | Left-shift count |
| halfMode | input | 1 | 0: four byte lanes, 1: two halfword lanes |
| csrWrEn | input | 1 | Status word write enable |
| csrWrData | input | 32 | Status word write data |
| result | output | 32 | Registered shifted word |
| csrValue | output | 32 | Status word; bit 22 is the sticky overflow flag |

## Verification
The assertions are checked on every cycle. They cover these behaviours:
- the result register holds when no operation is strobed;
- a zero shift copies the operand and raises no overflow;
- an overflow always leaves bit 22 set;
- bit 22 stays set until a write;
- a write loads the status word, except that a same-edge flag set takes bit 22;
- reset clears the status word.

Only the bench's scenarios can show that the per-lane results and the overflow decisions are correct. The bench compares them against an independent model using the halfword corner operands, the unsigned and signed overflow boundaries, an ignored fourth shift bit in byte mode, and seeded random traffic mixed with clearing writes.

// File: rtl/lshl_pkg.sv
package lshl_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic loadResult;
    logic halfSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/lshl_datapath.sv
module lshl_datapath
  import lshl_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHAMT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [WORD_W-1:0]  operand,
  input  logic [SHAMT_W-1:0] shiftAmt,
  output logic [WORD_W-1:0]  result,
  output logic               anyOvf
);
  localparam int BYTE_N = WORD_W / BYTE_W;
  localparam int HALF_N = WORD_W / HALF_W;
  localparam int BSH_W  = $clog2(BYTE_W);

  logic [BSH_W-1:0]  byteAmt;
  logic [WORD_W-1:0] byteRes, halfRes, nextRes;
  logic [BYTE_N-1:0] byteOvf;
  logic [HALF_N-1:0] halfOvf;

  assign byteAmt = shiftAmt[BSH_W-1:0];

  // Unsigned lanes: widen with zeros, anything landing above the lane is lost data.
  for (genvar g = 0; g < BYTE_N; g++) begin : g_byte
    logic [2*BYTE_W-1:0] wide;
    assign wide = {{BYTE_W{1'b0}}, operand[g*BYTE_W +: BYTE_W]} << byteAmt;
    assign byteRes[g*BYTE_W +: BYTE_W] = wide[BYTE_W-1:0];
    assign byteOvf[g] = |wide[2*BYTE_W-1:BYTE_W];
  end

  // Signed lanes: widen with the sign, the new sign plus everything above must agree.
  for (genvar g = 0; g < HALF_N; g++) begin : g_half
    logic [2*HALF_W-1:0] wide;
    logic [HALF_W:0]     topBits;
    assign wide    = {{HALF_W{operand[g*HALF_W+HALF_W-1]}}, operand[g*HALF_W +: HALF_W]} << shiftAmt;
    assign topBits = wide[2*HALF_W-1:HALF_W-1];
    assign halfRes[g*HALF_W +: HALF_W] = wide[HALF_W-1:0];
    assign halfOvf[g] = !((&topBits) || !(|topBits));
  end

  assign nextRes = strobes.halfSel ? halfRes : byteRes;
  assign anyOvf  = strobes.halfSel ? |halfOvf : |byteOvf;

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (strobes.loadResult) result <= nextRes;
  end

  logic zeroShift;
  assign zeroShift = strobes.halfSel ? (shiftAmt == '0) : (byteAmt == '0);

  p_zero_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadResult && zeroShift) |=> (result == $past(operand)));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    zeroShift |-> !anyOvf);
  p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadResult |=> $stable(result));
endmodule

// File: rtl/lshl_ctrl.sv
module lshl_ctrl
  import lshl_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int FLAG_POS = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              halfMode,
  input  logic              anyOvf,
  input  logic              csrWrEn,
  input  logic [WORD_W-1:0] csrWrData,
  output ctrlStrobes_t      strobes,
  output logic [WORD_W-1:0] csrValue
);
  logic flagSet;

  assign strobes.loadResult = inValid;
  assign strobes.halfSel    = halfMode;
  assign flagSet            = inValid && anyOvf;

  // A flag set is applied after the write so it wins on the flag bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      csrValue <= '0;
    end else begin
      if (csrWrEn) csrValue <= csrWrData;
      if (flagSet) csrValue[FLAG_POS] <= 1'b1;
    end
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && anyOvf) |=> csrValue[FLAG_POS]);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (!csrWrEn && csrValue[FLAG_POS]) |=> csrValue[FLAG_POS]);
  p_write_r8: assert property (@(posedge clk) disable iff (rst)
    (csrWrEn && !(inValid && anyOvf)) |=> (csrValue == $past(csrWrData)));
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (csrValue == '0));
endmodule

// File: rtl/lane_shl_unit.sv
module lane_shl_unit
  import lshl_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int SHAMT_W  = 4,
  parameter int FLAG_POS = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [WORD_W-1:0]  operand,
  input  logic [SHAMT_W-1:0] shiftAmt,
  input  logic               halfMode,
  input  logic               csrWrEn,
  input  logic [WORD_W-1:0]  csrWrData,
  output logic [WORD_W-1:0]  result,
  output logic [WORD_W-1:0]  csrValue
);
  ctrlStrobes_t strobes;
  logic         anyOvf;

  lshl_ctrl #(.WORD_W(WORD_W), .FLAG_POS(FLAG_POS)) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .halfMode(halfMode),
    .anyOvf(anyOvf), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .strobes(strobes), .csrValue(csrValue)
  );

  lshl_datapath #(.WORD_W(WORD_W), .SHAMT_W(SHAMT_W)) i_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .operand(operand),
    .shiftAmt(shiftAmt), .result(result), .anyOvf(anyOvf)
  );
endmodule

// File: tb/test_lane_shl_unit.sv
`timescale 1ns/1ps
module test_lane_shl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] operand = '0;
  logic [3:0]  shiftAmt = '0;
  logic        halfMode = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [31:0] csrWrData = '0;
  logic [31:0] result, csrValue;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] resModel = '0;
  logic [31:0] csrModel = '0;

  always #2 clk = ~clk;

  lane_shl_unit i_lane_shl_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .operand(operand),
    .shiftAmt(shiftAmt), .halfMode(halfMode), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .result(result), .csrValue(csrValue)
  );

  function automatic logic [31:0] modelRes(logic [31:0] op, logic [3:0] amt, logic half);
    logic [31:0] r = '0;
    if (half) begin
      for (int i = 0; i < 2; i++) begin
        int signed v = int'($signed(op[i*16 +: 16]));
        int signed w = v <<< amt;
        r[i*16 +: 16] = w[15:0];
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        int unsigned w = int'(op[i*8 +: 8]) << amt[2:0];
        r[i*8 +: 8] = w[7:0];
      end
    end
    return r;
  endfunction

  function automatic bit modelOvf(logic [31:0] op, logic [3:0] amt, logic half);
    bit o = 1'b0;
    if (half) begin
      for (int i = 0; i < 2; i++) begin
        int signed w = int'($signed(op[i*16 +: 16])) <<< amt;
        int signed top = w >>> 15;
        if (top != 0 && top != -1) o = 1'b1;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        int unsigned w = int'(op[i*8 +: 8]) << amt[2:0];
        if ((w >> 8) != 0) o = 1'b1;
      end
    end
    return o;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; applies inputs, waits one edge, checks at the next negedge.
  task automatic step(logic v, logic [31:0] op, logic [3:0] amt, logic half,
                      logic we, logic [31:0] wd, string tag);
    inValid = v; operand = op; shiftAmt = amt; halfMode = half;
    csrWrEn = we; csrWrData = wd;
    if (we) csrModel = wd;
    if (v) begin
      resModel = modelRes(op, amt, half);
      if (modelOvf(op, amt, half)) csrModel[22] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0; csrWrEn = 1'b0;
    check({tag, " result"}, result, resModel);
    check({tag, " status"}, csrValue, csrModel);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    resModel = '0; csrModel = '0;
    check("R9 result after reset", result, 32'h0);
    check("R9 status after reset", csrValue, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    doReset();
    // R1 R2: byte lane to the top without losing a bit
    step(1, 32'h0000_0001, 4'd7, 0, 0, 0, "R1 byte s7 no overflow");
    // R2: unsigned overflow in several lanes
    step(1, 32'h8765_4321, 4'd3, 0, 0, 0, "R2 byte s3 overflow");
    check("R2 flag bit", {31'b0, csrValue[22]}, 32'h1);
    step(0, 32'h0, 4'd0, 0, 1, 32'h0, "R8 clear");
    // R3 R4: signed halfword overflow in both lanes
    step(1, 32'h7FFF_8000, 4'd1, 1, 0, 0, "R4 half s1");
    check("R4 half s1 value", result, 32'hFFFE_0000);
    step(0, 32'h0, 4'd0, 0, 1, 32'h0, "R8 clear");
    step(1, 32'h0000_0001, 4'd15, 1, 0, 0, "R4 half s15 sign change");
    check("R4 half s15 value", result, 32'h0000_8000);
    step(0, 32'h0, 4'd0, 0, 1, 32'h0, "R8 clear");
    // R3: fits as signed, no overflow
    step(1, 32'hFFC0_0020, 4'd9, 1, 0, 0, "R3 half s9 fits");
    // R5: zero shift in both modes
    step(1, 32'hFFFF_8001, 4'd0, 1, 0, 0, "R5 half s0");
    step(1, 32'hFFFF_FFFF, 4'd8, 0, 0, 0, "R5 byte low bits zero");
    check("R5 byte pass value", result, 32'hFFFF_FFFF);
    // R1: bit 3 ignored in byte mode
    step(1, 32'h0101_0101, 4'b1011, 0, 0, 0, "R1 byte bit3 ignored");
    check("R1 byte bit3 value", result, 32'h0808_0808);
    // R6 R7: overflow then idle cycles: flag and result hold
    step(1, 32'h4000_0000, 4'd2, 0, 0, 0, "R6 byte overflow");
    step(0, 32'h1234_5678, 4'd4, 1, 0, 0, "R7 idle hold 1");
    step(0, 32'h8000_0000, 4'd5, 0, 0, 0, "R7 idle hold 2");
    // R8: write with a simultaneous overflow: bit 22 still set
    step(1, 32'h0000_8000, 4'd1, 1, 1, 32'h0000_00F0, "R8 collision");
    check("R8 collision value", csrValue, 32'h0040_00F0);
    // R9: reset mid-run
    doReset();
    for (int n = 0; n < 400; n++) begin
      logic we = ($urandom() % 8) == 0;
      step($urandom() % 4 != 0, $urandom(), 4'($urandom()), 1'($urandom()),
           we, we ? 32'h0 : 32'h0, "R6 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule